// File: doc/BRIEF.md
# Two-Tier Interrupt Arbitration Unit

This block sits between a group of timer submodules and a shared interrupt bus. Each submodule may hold an interrupt request tagged with a 3-bit priority level and a private one-bit band select. The block keeps one 3-bit arbitration field that all of its submodules share. When the bus runs an acknowledge cycle for a level, the block builds a 4-bit arbitration number for each request at that level. The band select supplies the top bit of the number and the shared field supplies the lower three bits. The block picks its own best request and compares that number against the best number offered by competing modules.

One cycle after the acknowledge, the block reports the result. It says whether it won, which submodule won, and whether the cycle was spurious because nobody at all took part. On a win it pulses a clear toward the winning submodule. Because the top bit belongs to each requester, one module's requests at a single level can sit in two separate priority bands, interleaved with other modules' numbers.

Top module: `irqarb_top`

## Requirements
- R1: The shared 3-bit field `field_q` is zero after reset. A write (`wr_en` high) loads `wr_data` into it, visible from the following cycle. Without a write it holds its value.
- R2: A request takes part only if its valid bit is set and its level equals `iack_level`. Level 0 means "no interrupt" and never takes part, even when `iack_level` is 0.
- R3: The arbitration number of request i is {`req_top[i]`, `field_q`}, where `req_top` supplies bit 3. A request whose number is 0 never takes part.
- R4: Among the requests that take part, the numerically highest number is chosen. When numbers are equal, the lowest index wins.
- R5: `win` is set only if the best local number is strictly greater than `ext_best_arb`. An equal number counts as a loss. When `win` is low, `winner_idx` is 0; when `win` is high it is the chosen index.
- R6: `done`, `win`, `winner_idx`, `spurious` and `clear_req` are registered. They reflect the acknowledge sampled at the previous clock edge. Without an acknowledge in that cycle, all of them are 0.
- R7: `clear_req` is one-hot at the winner's bit in exactly the cycle `win` is high, and it is all-zero otherwise.
- R8: `spurious` is high after an acknowledge only when no local request takes part and `ext_best_arb` is 0.
- R9: When a field write and an acknowledge happen in the same cycle, the arbitration uses the field value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N | Request pending per submodule |
| req_level | input | 3*N | Priority level per submodule, 3 bits each, index i at [3i+2:3i] |
| req_top | input | N | Per-submodule arbitration bit 3 |
| wr_en | input | 1 | Shared field write strobe |
| wr_data | input | 3 | Shared field write value |
| field_q | output | 3 | Shared field read-back |
| iack_valid | input | 1 | Acknowledge cycle present |
| iack_level | input | 3 | Level being acknowledged |
| ext_best_arb | input | 4 | Best number from other modules, 0 = none |
| done | output | 1 | Result valid, one cycle after acknowledge |
| win | output | 1 | This block won the arbitration |
| winner_idx | output | $clog2(N) | Winning submodule index |
| spurious | output | 1 | Nobody took part in the acknowledge |
| clear_req | output | N | One-hot drop pulse to the winner |

## Verification
On every cycle the assertions check the following:
- the timing of the result relative to the acknowledge;
- that win and spurious are mutually exclusive;
- that the clear pulse is one-hot and points at the reported winner;
- that spurious implies a zero external number;
- the write and hold behaviour of the shared field.

Some behaviours need a reference model of the whole request set, so only the bench's scenarios can show them:
- the choice of the highest number;
- lowest-index tie breaking;
- level filtering, including level 0;
- the strictly-greater rule against `ext_best_arb`;
- the use of the pre-write field value in a same-cycle write.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  localparam int LVL_W   = 3;
  localparam int FIELD_W = 3;
  localparam int ARB_W   = FIELD_W + 1;
  typedef logic [ARB_W-1:0]   arb_num_t;
  typedef logic [LVL_W-1:0]   lvl_t;
  typedef logic [FIELD_W-1:0] field_t;
endpackage

// File: rtl/irqarb_field_reg.sv
module irqarb_field_reg
  import irqarb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  field_t wr_data,
  output field_t field_q
);
  field_t field_d;

  always_comb begin
    field_d = field_q;
    if (wr_en) field_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) field_q <= '0;
    else        field_q <= field_d;
  end
endmodule

// File: rtl/irqarb_elig.sv
module irqarb_elig
  import irqarb_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]       req_valid,
  input  logic [LVL_W*N-1:0] req_level,
  input  logic [N-1:0]       req_top,
  input  field_t             field,
  input  lvl_t               iack_level,
  output logic [N-1:0]       elig,
  output logic [ARB_W*N-1:0] num_flat
);
  for (genvar g = 0; g < N; g++) begin : g_req
    lvl_t     lvl;
    arb_num_t num;
    assign lvl = req_level[g*LVL_W +: LVL_W];
    assign num = {req_top[g], field};
    assign num_flat[g*ARB_W +: ARB_W] = num;
    assign elig[g] = req_valid[g] && (lvl != '0) && (lvl == iack_level) && (num != '0);
  end
endmodule

// File: rtl/irqarb_select.sv
module irqarb_select
  import irqarb_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       elig,
  input  logic [ARB_W*N-1:0] num_flat,
  output logic               any,
  output arb_num_t           best,
  output logic [IDX_W-1:0]   best_idx
);
  always_comb begin
    best     = '0;
    best_idx = '0;
    // Scan downward; >= lets a lower index take over an equal number.
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i] && (num_flat[i*ARB_W +: ARB_W] >= best)) begin
        best     = num_flat[i*ARB_W +: ARB_W];
        best_idx = IDX_W'(i);
      end
    end
    any = |elig;
  end
endmodule

// File: rtl/irqarb_top.sv
module irqarb_top
  import irqarb_pkg::*;
#(
  parameter int N     = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req_valid,
  input  logic [3*N-1:0]   req_level,
  input  logic [N-1:0]     req_top,
  input  logic             wr_en,
  input  logic [2:0]       wr_data,
  output logic [2:0]       field_q,
  input  logic             iack_valid,
  input  logic [2:0]       iack_level,
  input  logic [3:0]       ext_best_arb,
  output logic             done,
  output logic             win,
  output logic [IDX_W-1:0] winner_idx,
  output logic             spurious,
  output logic [N-1:0]     clear_req
);
  logic [N-1:0]       elig;
  logic [ARB_W*N-1:0] num_flat;
  logic               any;
  arb_num_t           best;
  logic [IDX_W-1:0]   best_idx;

  logic             done_d, win_d, spur_d;
  logic [IDX_W-1:0] idx_d;
  logic [N-1:0]     clr_d;

  irqarb_field_reg u_field (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .field_q (field_q)
  );

  irqarb_elig #(.N(N)) u_elig (
    .req_valid  (req_valid),
    .req_level  (req_level),
    .req_top    (req_top),
    .field      (field_q),
    .iack_level (iack_level),
    .elig       (elig),
    .num_flat   (num_flat)
  );

  irqarb_select #(.N(N), .IDX_W(IDX_W)) u_sel (
    .elig     (elig),
    .num_flat (num_flat),
    .any      (any),
    .best     (best),
    .best_idx (best_idx)
  );

  always_comb begin
    done_d = iack_valid;
    win_d  = iack_valid && any && (best > ext_best_arb);
    spur_d = iack_valid && !any && (ext_best_arb == '0);
    idx_d  = win_d ? best_idx : '0;
    clr_d  = '0;
    if (win_d) clr_d[best_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      win        <= 1'b0;
      spurious   <= 1'b0;
      winner_idx <= '0;
      clear_req  <= '0;
    end else begin
      done       <= done_d;
      win        <= win_d;
      spurious   <= spur_d;
      winner_idx <= idx_d;
      clear_req  <= clr_d;
    end
  end
endmodule

// File: rtl/irqarb_chk.sv
module irqarb_chk #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iack_valid,
  input logic [3:0]       ext_best_arb,
  input logic             wr_en,
  input logic [2:0]       wr_data,
  input logic [2:0]       field_q,
  input logic             done,
  input logic             win,
  input logic [IDX_W-1:0] winner_idx,
  input logic             spurious,
  input logic [N-1:0]     clear_req
);
  // R6
  done_after_iack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(iack_valid));
  // R6
  quiet_without_iack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!win && !spurious && clear_req == '0 && winner_idx == '0));
  // R5
  win_not_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win |-> !spurious);
  // R5
  win_beats_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win |-> $past(ext_best_arb) != 4'hF);
  // R7
  clear_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clear_req));
  // R7
  clear_at_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win |-> clear_req[winner_idx]);
  // R7
  clear_needs_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win |-> clear_req == '0);
  // R8
  spur_ext_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spurious |-> $past(ext_best_arb) == 4'h0);
  // R1
  field_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> field_q == $past(wr_data));
  // R1
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(field_q));
endmodule

bind irqarb_top irqarb_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .iack_valid   (iack_valid),
  .ext_best_arb (ext_best_arb),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .field_q      (field_q),
  .done         (done),
  .win          (win),
  .winner_idx   (winner_idx),
  .spurious     (spurious),
  .clear_req    (clear_req)
);

// File: tb/test_irqarb_top.sv
module test_irqarb_top;
  localparam int N      = 8;
  localparam int IDX_W  = $clog2(N);
  localparam int PERIOD = 10;

  logic             clk;
  logic             rst_n;
  logic [N-1:0]     req_valid;
  logic [3*N-1:0]   req_level;
  logic [N-1:0]     req_top;
  logic             wr_en;
  logic [2:0]       wr_data;
  logic [2:0]       field_q;
  logic             iack_valid;
  logic [2:0]       iack_level;
  logic [3:0]       ext_best_arb;
  logic             done, win, spurious;
  logic [IDX_W-1:0] winner_idx;
  logic [N-1:0]     clear_req;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [2:0] fld_model;

  irqarb_top #(.N(N)) i_irqarb_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .req_top(req_top), .wr_en(wr_en), .wr_data(wr_data), .field_q(field_q),
    .iack_valid(iack_valid), .iack_level(iack_level), .ext_best_arb(ext_best_arb),
    .done(done), .win(win), .winner_idx(winner_idx), .spurious(spurious),
    .clear_req(clear_req)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic             w;
    logic [IDX_W-1:0] idx;
    logic             sp;
    logic [N-1:0]     clr;
  } exp_t;

  // Reference model built from R2, R3, R4, R5, R7 and R8.
  function automatic exp_t model(input logic [N-1:0] v, input logic [3*N-1:0] lv,
                                 input logic [N-1:0] tp, input logic [2:0] fld,
                                 input logic [2:0] il, input logic [3:0] ext);
    exp_t e;
    logic [3:0] best = 4'd0;
    int bi = -1;
    e = '0;
    for (int i = 0; i < N; i++) begin
      logic [3:0] n;
      n = {tp[i], fld};
      if (v[i] && lv[3*i +: 3] != 3'd0 && lv[3*i +: 3] == il && n != 4'd0 && n > best) begin
        best = n;
        bi = i;
      end
    end
    if (bi >= 0 && best > ext) begin
      e.w = 1'b1;
      e.idx = IDX_W'(bi);
      e.clr[bi] = 1'b1;
    end
    if (bi < 0 && ext == 4'd0) e.sp = 1'b1;
    return e;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_field(input logic [2:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    fld_model = d;
    check("R1 write", 32'(field_q), 32'(d));
  endtask

  // Apply one acknowledge and check the registered result one edge later.
  task automatic ack(input string tag, input logic [2:0] il, input logic [3:0] ext);
    exp_t e;
    e = model(req_valid, req_level, req_top, fld_model, il, ext);
    iack_valid = 1'b1; iack_level = il; ext_best_arb = ext;
    @(negedge clk);
    iack_valid = 1'b0;
    check({tag, " R6 done"}, 32'(done), 32'd1);
    check({tag, " R5 win"}, 32'(win), 32'(e.w));
    check({tag, " R4 idx"}, 32'(winner_idx), 32'(e.idx));
    check({tag, " R8 spurious"}, 32'(spurious), 32'(e.sp));
    check({tag, " R7 clear"}, 32'(clear_req), 32'(e.clr));
    @(negedge clk);
    check({tag, " R6 idle"}, 32'({done, win, spurious, clear_req}), 32'd0);
  endtask

  function automatic void set_lvl(input int i, input logic [2:0] l);
    req_level[3*i +: 3] = l;
  endfunction

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; req_valid = '0; req_level = '0; req_top = '0;
    wr_en = 1'b0; wr_data = '0; iack_valid = 1'b0; iack_level = '0; ext_best_arb = '0;
    fld_model = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset value; R6 quiet outputs
    check("R1 reset field", 32'(field_q), 32'd0);
    check("R6 reset outputs", 32'({done, win, spurious, clear_req, winner_idx}), 32'd0);

    // R3: field 0, top 0 -> number 0 never takes part -> spurious
    req_valid = 8'h01; set_lvl(0, 3'd3); req_top = '0;
    ack("R3 zero num", 3'd3, 4'd0);
    // R3: top bit alone gives 1000 which takes part
    req_top = 8'h01;
    ack("R3 top only", 3'd3, 4'd7);

    // R4 tie: lower index wins
    write_field(3'd5);
    req_valid = 8'h0C; set_lvl(2, 3'd4); set_lvl(3, 3'd4); req_top = '0;
    ack("R4 tie", 3'd4, 4'd0);
    // R4 top band beats lower band at a higher index
    req_top = 8'h08;
    ack("R4 band", 3'd4, 4'd0);
    // R5 equal ext loses, lower ext wins
    ack("R5 equal", 3'd4, 4'hD);
    ack("R5 less", 3'd4, 4'hC);
    // R2 level mismatch, level 0 never eligible
    ack("R2 mismatch", 3'd6, 4'd0);
    req_valid = 8'h10; set_lvl(4, 3'd0);
    ack("R2 level0", 3'd0, 4'd0);
    // R8 no local but ext nonzero -> not spurious
    ack("R8 ext", 3'd1, 4'd2);

    // R9: write in the same cycle as an acknowledge uses the old field
    req_valid = 8'h01; set_lvl(0, 3'd2); req_top = '0;
    write_field(3'd0);
    wr_en = 1'b1; wr_data = 3'd7;
    ack("R9 same-cycle", 3'd2, 4'd0);
    wr_en = 1'b0;
    fld_model = 3'd7;
    check("R9 field after", 32'(field_q), 32'd7);

    // Random mix: R2 R3 R4 R5 R7 R8
    for (int t = 0; t < 400; t++) begin
      if ($urandom_range(0, 3) == 0) write_field(3'($urandom_range(0, 7)));
      req_valid = N'($urandom);
      req_top   = N'($urandom);
      for (int i = 0; i < N; i++) set_lvl(i, 3'($urandom_range(0, 7)));
      ack("RND", 3'($urandom_range(0, 7)),
          ($urandom_range(0, 2) == 0) ? 4'd0 : 4'($urandom_range(0, 15)));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule